// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block sits next to the delayed-transaction queue of a bus bridge. When a completed delayed transaction reaches the head of that queue, the block starts timing how long the original initiator takes to come back and repeat its request. If the initiator returns, the count is abandoned. If it does not return before the timeout, the block tells the queue to drop the entry.

A free-running prescaler produces a tick every 2^LONG_SHIFT clocks, or every 2^SHORT_SHIFT clocks when the short-range select is set. The entry is discarded on the second tick seen after counting starts, so the wait falls between one and two prescaler periods.

On expiry the block does three things:
- It pulses a discard strobe for one clock.
- It sets a sticky status flag, which software clears by writing a one.
- If error reporting is enabled, it pulses an error line toward the primary side.

Top module: `dxq_discard_timer`

## Requirements
- R1: After reset, `discard_o`, `sys_err_o` and `status_o` are 0.
- R2: With `head_valid` low, no discard, error or status is produced, however long the block runs.
- R3: The prescaler value is the number of clock edges since reset was released, modulo 2^LONG_SHIFT. Edge i is a tick when the low n bits of i are all ones, where n = LONG_SHIFT if `sel_short`=0. Counting starts at the edge s that first samples `head_valid`=1 with `retry_seen`=0. Expiry is at the second tick edge e with e > s. `discard_o` is high from edge e to edge e+1. This gives 2^n < e-s <= 2^(n+1).
- R4: With `sel_short`=1, the timing of R3 applies with n = SHORT_SHIFT.
- R5: A `retry_seen` pulse before expiry ends the count with no discard, no error and no status change.
- R6: `head_valid` falling before expiry ends the count with no discard, no error and no status change.
- R7: Each expiry holds `discard_o` high for exactly one clock.
- R8: `status_o` goes to 1 in the same cycle as `discard_o`. It then stays at 1 while `status_w1c`=0, and returns to 0 on the edge after `status_w1c`=1.
- R9: If `status_w1c`=1 at the same edge as an expiry, `status_o` ends up 1.
- R10: `sys_err_o` pulses together with `discard_o` exactly when `err_en` was 1 at the expiry edge. Otherwise it stays 0.
- R11: The block does not restart counting while `discard_o` is high. A head entry present after the strobe gets a fresh count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_valid | input | 1 | A delayed completion waits at the queue head |
| retry_seen | input | 1 | The initiator repeated the request this cycle |
| sel_short | input | 1 | 1 selects the short timeout range, 0 the long one |
| err_en | input | 1 | Allows the error pulse on expiry |
| status_w1c | input | 1 | Write-one strobe that clears the status flag |
| discard_o | output | 1 | One-cycle discard command to the queue |
| sys_err_o | output | 1 | One-cycle error pulse toward the primary side |
| status_o | output | 1 | Sticky expiry status |

## Verification
A wrong state in the watcher shows up on `discard_o` at the wrong edge. A missing transition delays the strobe by a whole prescaler period, and an extra transition brings it one period early. Because the bench knows the exact expiry edge for every start phase of a small configuration, either error appears within at most two prescaler periods of the start.

A corrupted status or error register is seen on the cycle of the strobe, or at the first clear-write that follows it.

// File: rtl/dtt_pkg.sv
// Shared types for the discard timer. Assumes nothing beyond IEEE 1800-2017.
package dtt_pkg;
    // Watcher progress: no count, waiting for first tick, waiting for second tick.
    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ARMED = 2'd1,
        W_HALF  = 2'd2
    } watch_state_e;
endpackage

// File: rtl/dtt_prescaler.sv
// Free-running prescaler. It emits a tick on the last count of either the long
// or the short period. Assumes SHORT_SHIFT <= LONG_SHIFT, so both periods stay
// aligned to one counter.
module dtt_prescaler #(
    parameter int LONG_SHIFT  = 15,
    parameter int SHORT_SHIFT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_short,
    output logic tick_o
);
    localparam logic [LONG_SHIFT-1:0] LONG_MASK  = {LONG_SHIFT{1'b1}};
    localparam logic [LONG_SHIFT-1:0] SHORT_MASK = LONG_MASK >> (LONG_SHIFT - SHORT_SHIFT);

    logic [LONG_SHIFT-1:0] cnt_q;
    logic                  tick_long;
    logic                  tick_short;

    // Advance the prescaler on every clock; reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Detect the end of the selected period.
    always_comb begin
        tick_long  = (cnt_q == LONG_MASK);
        tick_short = ((cnt_q & SHORT_MASK) == SHORT_MASK);
        tick_o     = sel_short ? tick_short : tick_long;
    end

    // Parameter sanity check at elaboration time.
    initial begin
        if (SHORT_SHIFT > LONG_SHIFT || SHORT_SHIFT < 1)
            $error("dtt_prescaler: SHORT_SHIFT out of range");
    end

    // The long tick implies the short tick, so ticks never leave the common grid (R4).
    p_tick_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_long |-> tick_short);
endmodule

// File: rtl/dtt_watch.sv
// Watches the head entry and flags expiry on the second prescaler tick after
// counting starts. Assumes retry_seen and head_valid are synchronous to clk.
// A retry or a departing head entry at the expiry edge wins over expiry.
module dtt_watch
    import dtt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic retry_seen,
    input  logic tick,
    input  logic strobe_busy,
    output logic expire_now
);
    watch_state_e state_q, state_d;
    logic         keep;

    // Next-state selection and the expiry decision.
    always_comb begin
        keep       = head_valid && !retry_seen;
        state_d    = state_q;
        expire_now = 1'b0;
        unique case (state_q)
            W_IDLE:  if (keep && !strobe_busy) state_d = W_ARMED;
            W_ARMED: if (!keep) state_d = W_IDLE;
                     else if (tick) state_d = W_HALF;
            W_HALF:  if (!keep) state_d = W_IDLE;
                     else if (tick) begin
                         state_d    = W_IDLE;
                         expire_now = 1'b1;
                     end
            default: state_d = W_IDLE;
        endcase
    end

    // Hold the watcher state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    p_retry_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_seen |=> (state_q == W_IDLE));
    p_head_gone_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |=> (state_q == W_IDLE));
    p_no_rearm_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_IDLE && strobe_busy) |=> (state_q == W_IDLE));
endmodule

// File: rtl/dtt_report.sv
// Registers the expiry outputs: the discard strobe, the gated error pulse and
// the sticky write-one-to-clear status flag. A set wins over a clear.
module dtt_report (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_now,
    input  logic err_en,
    input  logic status_w1c,
    output logic discard_o,
    output logic sys_err_o,
    output logic status_o
);
    logic discard_q;
    logic sys_err_q;
    logic status_q;

    // Register the one-cycle strobe and the enabled error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            discard_q <= 1'b0;
            sys_err_q <= 1'b0;
        end else begin
            discard_q <= expire_now;
            sys_err_q <= expire_now && err_en;
        end
    end

    // Sticky status: set on expiry, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)          status_q <= 1'b0;
        else if (expire_now) status_q <= 1'b1;
        else if (status_w1c) status_q <= 1'b0;
    end

    assign discard_o = discard_q;
    assign sys_err_o = sys_err_q;
    assign status_o  = status_q;

    p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        discard_o |=> !discard_o);
    p_status_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        discard_o |-> status_o);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !status_w1c) |=> status_o);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_now && status_w1c) |=> status_o);
    p_err_with_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err_o |-> discard_o);
endmodule

// File: rtl/dxq_discard_timer.sv
// Top of the delayed-transaction discard timer. It combines the prescaler,
// the head watcher and the output registers. Assumes all inputs are
// synchronous to clk and that the queue pops its head at the end of the
// discard strobe cycle.
module dxq_discard_timer #(
    parameter int LONG_SHIFT  = 15,
    parameter int SHORT_SHIFT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic retry_seen,
    input  logic sel_short,
    input  logic err_en,
    input  logic status_w1c,
    output logic discard_o,
    output logic sys_err_o,
    output logic status_o
);
    logic tick;
    logic expire_now;

    dtt_prescaler #(
        .LONG_SHIFT (LONG_SHIFT),
        .SHORT_SHIFT(SHORT_SHIFT)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_short(sel_short),
        .tick_o   (tick)
    );

    dtt_watch u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .retry_seen (retry_seen),
        .tick       (tick),
        .strobe_busy(discard_o),
        .expire_now (expire_now)
    );

    dtt_report u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_now(expire_now),
        .err_en    (err_en),
        .status_w1c(status_w1c),
        .discard_o (discard_o),
        .sys_err_o (sys_err_o),
        .status_o  (status_o)
    );

    p_no_head_no_discard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |=> !discard_o);
    p_retry_no_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_seen |=> !discard_o);
endmodule

// File: tb/dxq_discard_timer_bench.sv
module dxq_discard_timer_bench;
    localparam int LH = 4;
    localparam int SH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic head_valid = 1'b0;
    logic retry_seen = 1'b0;
    logic sel_short = 1'b0;
    logic err_en = 1'b0;
    logic status_w1c = 1'b0;
    logic discard_o, sys_err_o, status_o;
    int   eidx = 0;
    int   n_chk = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    // Count the clock edges since reset release; the value before edge i is i.
    always @(posedge clk) begin
        if (!rst_n) eidx <= 0;
        else        eidx <= eidx + 1;
    end

    dxq_discard_timer #(.LONG_SHIFT(LH), .SHORT_SHIFT(SH)) u_dxq_discard_timer (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .retry_seen(retry_seen),
        .sel_short(sel_short), .err_en(err_en), .status_w1c(status_w1c),
        .discard_o(discard_o), .sys_err_o(sys_err_o), .status_o(status_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic clear_status();
        @(negedge clk); status_w1c = 1'b1;
        @(negedge clk); status_w1c = 1'b0;
    endtask

    // One expiry scenario, started at a chosen phase of the prescaler.
    task automatic run_expiry(input bit sel, input bit en, input int off, input bit clr_same);
        int n, np, s, exp_e, seen_e, pulses, errs, t;
        n = sel ? SH : LH;
        np = 1 << n;
        sel_short = sel;
        err_en = en;
        clear_status();
        while ((eidx % np) != off) @(negedge clk);
        head_valid = 1'b1;
        s = eidx;
        t = 0;
        exp_e = -1;
        for (int i = s + 1; i <= s + 2 * np; i++) begin
            if ((i % np) == np - 1) begin
                t++;
                if (t == 2 && exp_e < 0) exp_e = i;
            end
        end
        seen_e = -1; pulses = 0; errs = 0;
        repeat (2 * np + 4) begin
            @(negedge clk);
            if (discard_o) begin
                pulses++;
                if (seen_e < 0) seen_e = eidx;
                head_valid = 1'b0;
            end
            if (sys_err_o) errs++;
            if (discard_o && !status_o) chk(0, "R8 status with strobe", 0, 1);
            status_w1c = (clr_same && eidx == exp_e) ? 1'b1 : 1'b0;
        end
        status_w1c = 1'b0;
        head_valid = 1'b0;
        chk(seen_e == exp_e + 1, sel ? "R4 short expiry edge" : "R3 long expiry edge", seen_e, exp_e + 1);
        chk((seen_e - 1 - s) > np && (seen_e - 1 - s) <= 2 * np, "R3 delay range", seen_e - 1 - s, np);
        chk(pulses == 1, "R7 single strobe", pulses, 1);
        chk(errs == (en ? 1 : 0), "R10 error gating", errs, en ? 1 : 0);
        chk(status_o == 1'b1, clr_same ? "R9 set beats clear" : "R8 status set", status_o, 1);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk(discard_o == 0 && sys_err_o == 0 && status_o == 0, "R1 reset", {discard_o, sys_err_o, status_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(discard_o == 0 && sys_err_o == 0 && status_o == 0, "R1 after release", {discard_o, sys_err_o, status_o}, 0);

        // R2: idle for many periods with no head entry.
        cnt = 0;
        repeat (80) begin
            @(negedge clk);
            if (discard_o || sys_err_o || status_o) cnt++;
        end
        chk(cnt == 0, "R2 idle quiet", cnt, 0);

        // R3/R4/R7/R8/R10: sweep every start phase in both ranges.
        for (int off = 0; off < (1 << LH); off++) run_expiry(1'b0, off[0], off, 1'b0);
        for (int off = 0; off < (1 << SH); off++) begin
            run_expiry(1'b1, 1'b0, off, 1'b0);
            run_expiry(1'b1, 1'b1, off, 1'b0);
        end
        // R9: clear written at the expiry edge.
        run_expiry(1'b1, 1'b1, 1, 1'b1);
        run_expiry(1'b0, 1'b0, 5, 1'b1);

        // R8: status holds while writing zero, then clears on a write of one.
        repeat (6) @(negedge clk);
        chk(status_o == 1, "R8 hold on zero write", status_o, 1);
        clear_status();
        chk(status_o == 0, "R8 cleared by one", status_o, 0);

        // R5: a retry before expiry cancels the count.
        sel_short = 1'b1; err_en = 1'b1;
        head_valid = 1'b1;
        repeat (2) @(negedge clk);
        retry_seen = 1'b1; head_valid = 1'b0;
        @(negedge clk);
        retry_seen = 1'b0;
        cnt = 0;
        repeat (20) begin
            @(negedge clk);
            if (discard_o || sys_err_o || status_o) cnt++;
        end
        chk(cnt == 0, "R5 retry cancels", cnt, 0);

        // R5: a retry with the head still present restarts, so a late expiry edge follows.
        sel_short = 1'b0;
        while ((eidx % 16) != 0) @(negedge clk);
        head_valid = 1'b1;
        repeat (20) @(negedge clk);
        retry_seen = 1'b1;
        @(negedge clk);
        retry_seen = 1'b0;
        cnt = 0;
        repeat (16) begin
            @(negedge clk);
            if (discard_o) cnt++;
        end
        chk(cnt == 0, "R5 retry restarts count", cnt, 0);
        head_valid = 1'b0;

        // R6: the head leaving cancels the count.
        sel_short = 1'b1;
        @(negedge clk);
        head_valid = 1'b1;
        repeat (5) @(negedge clk);
        head_valid = 1'b0;
        cnt = 0;
        repeat (20) begin
            @(negedge clk);
            if (discard_o || sys_err_o || status_o) cnt++;
        end
        chk(cnt == 0, "R6 head leave cancels", cnt, 0);

        // R11: the head stays valid through the strobe, and a new entry gets a fresh count.
        sel_short = 1'b1;
        while ((eidx % 4) != 0) @(negedge clk);
        head_valid = 1'b1;
        cnt = 0;
        begin
            int first, second;
            first = -1; second = -1;
            repeat (30) begin
                @(negedge clk);
                if (discard_o) begin
                    if (first < 0) first = eidx;
                    else if (second < 0) second = eidx;
                end
            end
            // Start at edge e0 (eidx%4==0): expiry at e0+7. The re-arm is held for one
            // cycle, then starts at e0+9, so the next expiry is at e0+15, 8 edges later.
            chk(first > 0 && second - first == 8, "R11 fresh count", second - first, 8);
        end
        head_valid = 1'b0;
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule